// File: doc/BRIEF.md
# Lockable Late Debug Enable Gate

This block decides whether the gating around a debug module is opened. Three things feed the decision: the lifecycle state reported by the device, an 8-bit multi-bit policy value from one-time-programmed storage, and a 32-bit multi-bit enable register that software writes. The software register only matters in the development lifecycle state, and only while the policy value is not its multi-bit true code. Early boot firmware can therefore close off sensitive resources first and open debug afterwards. A sticky lock bit freezes the enable register. Software can clear the lock but can never set it again.

The block is reached through a plain 32-bit register port: an address, a write strobe, write data, and read data that is combinational from the address. The port has no handshake. Every write completes at the clock edge on which the strobe is high.

A third register location produces a fatal alert test pulse, so the alert path can be exercised. The debug-enable output is registered.

Top module: `dbg_gate_top`

## Requirements
- R1: After reset the lock register (offset 0x4) reads 0x00000001. The enable register (offset 0x8) reads 0x69696969. `dbg_en_o` and `alert_test_o` are 0.
- R2: A write to offset 0x0 with bit 0 set raises `alert_test_o` for exactly the cycle after the write edge. A write there with bit 0 clear produces no pulse. Reads of 0x0 return 0.
- R3: A write to offset 0x4 with bit 0 clear sets the lock bit to 0. A write with bit 0 set leaves it unchanged. Once 0, it stays 0 until reset. Reads of 0x4 return the lock in bit 0 and zeros elsewhere.
- R4: While the lock bit is 1, a write to offset 0x8 stores the full 32-bit word, and a read of 0x8 returns it. While the lock bit is 0, writes to 0x8 are ignored.
- R5: In lifecycle state DEV (code 3), when the policy input is anything other than 0x96, `dbg_en_o` is 1 only if the enable register holds exactly 0x96969696.
- R6: In lifecycle states TEST_UNLOCKED (code 1) and RMA (code 5), `dbg_en_o` is 1 whatever the enable register holds.
- R7: In DEV (code 3) with the policy input equal to 0x96, `dbg_en_o` is 1 whatever the enable register holds.
- R8: In TEST_LOCKED (code 2), PROD (code 4), INVALID (code 0) and the unassigned codes 6 and 7, `dbg_en_o` is 0 whatever the register or policy holds.
- R9: `dbg_en_o` is registered. It shows the decision for the inputs and register contents as they stood before the previous rising edge. A register write therefore reaches `dbg_en_o` one cycle after it lands.
- R10: Reads of any offset other than 0x0, 0x4 and 0x8 return 0. Writes to those offsets change no register and raise no alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 4 | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe, one write per high cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| lc_state_i | input | 3 | Lifecycle state code |
| policy_i | input | 8 | Multi-bit policy value from fused storage |
| dbg_en_o | output | 1 | Registered debug gate enable |
| alert_test_o | output | 1 | One-cycle fatal alert test pulse |

## Verification
A write to the enable register and a change of lifecycle state can land on the same clock edge. At that edge the decision logic still sees the old register contents together with the new state. The bench provokes this by moving the state from PROD to DEV with a non-true policy while, on the same edge, it writes the true code into the enable register. It then expects `dbg_en_o` to be 0 one cycle later and 1 the cycle after that.

A locked write followed by a state change is judged the same way. There `dbg_en_o` must stay 0.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;

  localparam int LcW = 3;

  typedef enum logic [LcW-1:0] {
    LC_INVALID  = 3'd0,
    LC_TEST_UNL = 3'd1,
    LC_TEST_LCK = 3'd2,
    LC_DEV      = 3'd3,
    LC_PROD     = 3'd4,
    LC_RMA      = 3'd5
  } lc_state_e;

  // multi-bit byte codes; wider words repeat the byte
  localparam logic [7:0] MB_TRUE_BYTE  = 8'h96;
  localparam logic [7:0] MB_FALSE_BYTE = 8'h69;

  // register byte offsets
  localparam int OFS_ALERT = 0;
  localparam int OFS_LOCK  = 4;
  localparam int OFS_LATE  = 8;

endpackage

// File: rtl/dbg_gate_mubi_eq.sv
module dbg_gate_mubi_eq #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  output logic         true_o
);
  import dbg_gate_pkg::*;

  localparam int NB = W / 8;

  logic [NB-1:0] byte_ok;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign byte_ok[b] = (val_i[b*8 +: 8] == MB_TRUE_BYTE);
  end

  assign true_o = &byte_ok;
endmodule

// File: rtl/dbg_gate_regs.sv
module dbg_gate_regs #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              lock_o,
  output logic [DATA_W-1:0] late_o,
  output logic              alert_o
);
  import dbg_gate_pkg::*;

  localparam logic [ADDR_W-1:0] A_ALERT = ADDR_W'(OFS_ALERT);
  localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(OFS_LOCK);
  localparam logic [ADDR_W-1:0] A_LATE  = ADDR_W'(OFS_LATE);
  localparam logic [DATA_W-1:0] LATE_RST = {(DATA_W/8){MB_FALSE_BYTE}};

  logic              hit_alert, hit_lock, hit_late;
  logic              lock_q;
  logic [DATA_W-1:0] late_q;
  logic              alert_q;

  assign hit_alert = (addr_i == A_ALERT);
  assign hit_lock  = (addr_i == A_LOCK);
  assign hit_late  = (addr_i == A_LATE);

  // lock bit: write-zero-to-clear, never set again
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    lock_q <= 1'b1;
    else if (we_i && hit_lock)      lock_q <= lock_q & wdata_i[0];
  end

  // late enable word, writable only while unlocked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          late_q <= LATE_RST;
    else if (we_i && hit_late && lock_q)  late_q <= wdata_i;
  end

  // alert test pulse, one cycle per qualifying write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_q <= 1'b0;
    else         alert_q <= we_i && hit_alert && wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    if (hit_lock)      rdata_o[0] = lock_q;
    else if (hit_late) rdata_o    = late_q;
  end

  assign lock_o  = lock_q;
  assign late_o  = late_q;
  assign alert_o = alert_q;
endmodule

// File: rtl/dbg_gate_policy.sv
module dbg_gate_policy #(
  parameter int DATA_W = 32,
  parameter int POL_W  = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [dbg_gate_pkg::LcW-1:0]   lc_i,
  input  logic [POL_W-1:0]               policy_i,
  input  logic [DATA_W-1:0]              late_i,
  output logic                           en_o
);
  import dbg_gate_pkg::*;

  logic pol_true, late_true, en_d, en_q;

  dbg_gate_mubi_eq #(.W(POL_W)) u_pol_eq (
    .val_i  (policy_i),
    .true_o (pol_true)
  );

  dbg_gate_mubi_eq #(.W(DATA_W)) u_late_eq (
    .val_i  (late_i),
    .true_o (late_true)
  );

  always_comb begin
    case (lc_i)
      LC_TEST_UNL, LC_RMA: en_d = 1'b1;
      LC_DEV:              en_d = pol_true | late_true;
      default:             en_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/dbg_gate_top.sv
module dbg_gate_top #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int POL_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [2:0]        lc_state_i,
  input  logic [POL_W-1:0]  policy_i,
  output logic              dbg_en_o,
  output logic              alert_test_o
);
  logic              lock_w;
  logic [DATA_W-1:0] late_w;

  dbg_gate_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .we_i    (bus_we_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .lock_o  (lock_w),
    .late_o  (late_w),
    .alert_o (alert_test_o)
  );

  dbg_gate_policy #(.DATA_W(DATA_W), .POL_W(POL_W)) u_policy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lc_i     (lc_state_i),
    .policy_i (policy_i),
    .late_i   (late_w),
    .en_o     (dbg_en_o)
  );
endmodule

// File: rtl/dbg_gate_chk.sv
module dbg_gate_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [2:0]        lc_state_i,
  input logic              dbg_en_o,
  input logic              alert_test_o,
  input logic              lock_w,
  input logic [DATA_W-1:0] late_w
);
  logic alert_wr, mapped;
  assign alert_wr = bus_we_i && (bus_addr_i == ADDR_W'(0)) && bus_wdata_i[0];
  assign mapped   = (bus_addr_i == ADDR_W'(0)) || (bus_addr_i == ADDR_W'(4))
                 || (bus_addr_i == ADDR_W'(8));

  a_r2_alert_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_wr |=> alert_test_o);

  a_r2_no_spurious_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alert_wr |=> !alert_test_o);

  a_r3_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_w |=> !lock_w);

  a_r4_locked_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_w && bus_we_i && bus_addr_i == ADDR_W'(8)) |=> $stable(late_w));

  a_r6_open_states: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lc_state_i == 3'd1 || lc_state_i == 3'd5) |=> dbg_en_o);

  a_r8_closed_states: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lc_state_i != 3'd1 && lc_state_i != 3'd3 && lc_state_i != 3'd5) |=> !dbg_en_o);

  a_r10_unmapped_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (bus_rdata_o == '0));
endmodule

bind dbg_gate_top dbg_gate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_addr_i   (bus_addr_i),
  .bus_we_i     (bus_we_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .lc_state_i   (lc_state_i),
  .dbg_en_o     (dbg_en_o),
  .alert_test_o (alert_test_o),
  .lock_w       (lock_w),
  .late_w       (late_w)
);

// File: tb/dbg_gate_top_test.sv
`timescale 1ns/1ps
module dbg_gate_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  lc = 3'd0;
  logic [7:0]  pol = 8'h00;
  logic        en, alert;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [31:0] T32 = 32'h96969696;
  localparam logic [31:0] F32 = 32'h69696969;

  always #4 clk = ~clk;

  dbg_gate_top uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .lc_state_i(lc),
    .policy_i(pol), .dbg_en_o(en), .alert_test_o(alert)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // starts and ends at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  function automatic logic exp_en(input int s, input logic [7:0] p, input logic [31:0] l);
    if (s == 1 || s == 5) return 1'b1;
    if (s == 3) return (p == 8'h96) || (l == T32);
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lates [4];
    lates[0] = T32; lates[1] = F32; lates[2] = 32'h96969697; lates[3] = 32'h16969696;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h4, d); chk("R1 lock reset", d, 32'h1);
    rd(4'h8, d); chk("R1 late reset", d, F32);
    chk("R1 dbg_en reset", {31'b0, en}, 0);
    chk("R1 alert reset", {31'b0, alert}, 0);

    // R2 alert test
    rd(4'h0, d); chk("R2 read alert ofs", d, 0);
    wr(4'h0, 32'h1);
    chk("R2 alert pulse", {31'b0, alert}, 1);
    @(negedge clk);
    chk("R2 alert single cycle", {31'b0, alert}, 0);
    wr(4'h0, 32'hFFFF_FFFE);
    chk("R2 bit0 clear no pulse", {31'b0, alert}, 0);

    // R10 unmapped offsets
    wr(4'hC, T32);
    chk("R10 no alert from unmapped", {31'b0, alert}, 0);
    rd(4'h8, d); chk("R10 late unchanged", d, F32);
    wr(4'h5, 32'h0);
    rd(4'h4, d); chk("R10 lock unchanged", d, 32'h1);
    for (int a = 0; a < 16; a++) begin
      if (a != 4 && a != 8) begin
        rd(a[3:0], d); chk("R10 unmapped read zero", d, 0);
      end
    end

    // R3 setting attempt while set keeps 1
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R3 lock write one keeps", d, 32'h1);

    // sweep: R4 R5 R6 R7 R8 R9
    for (int li = 0; li < 4; li++) begin
      wr(4'h8, lates[li]);
      rd(4'h8, d); chk("R4 late readback", d, lates[li]);
      for (int s = 0; s < 8; s++) begin
        for (int p = 0; p < 256; p++) begin
          lc = s[2:0]; pol = p[7:0];
          @(negedge clk);
          chk(s == 3 ? (p == 8'h96 ? "R7 dev policy true" : "R5 dev late gate")
                     : ((s == 1 || s == 5) ? "R6 open state" : "R8 closed state"),
              {31'b0, en}, {31'b0, exp_en(s, p[7:0], lates[li])});
        end
      end
    end

    // R9 same-edge state change and register write
    lc = 3'd4; pol = 8'h00;
    wr(4'h8, F32);
    @(negedge clk);
    chk("R9 prod closed", {31'b0, en}, 0);
    lc = 3'd3; addr = 4'h8; wdata = T32; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    chk("R9 old register seen", {31'b0, en}, 0);
    @(negedge clk);
    chk("R9 new register seen", {31'b0, en}, 1);
    lc = 3'd4;
    @(negedge clk);
    chk("R9 leaves dev", {31'b0, en}, 0);

    // R3 R4 lock behaviour
    lc = 3'd3;
    wr(4'h8, F32);
    wr(4'h4, 32'hFFFF_FFFE);
    rd(4'h4, d); chk("R3 lock cleared", d, 0);
    wr(4'h4, 32'h1);
    rd(4'h4, d); chk("R3 lock stays clear", d, 0);
    wr(4'h8, T32);
    rd(4'h8, d); chk("R4 locked write ignored", d, F32);
    @(negedge clk);
    chk("R4 locked gate stays shut", {31'b0, en}, 0);
    pol = 8'h96;
    @(negedge clk);
    chk("R7 policy opens when locked", {31'b0, en}, 1);

    done = 1;
    summary();
  end
endmodule